// File: doc/BRIEF.md
# Handshaked Binary Pointer Crossing

This block moves a multi-bit binary FIFO pointer from a source clock domain into an unrelated destination clock domain without Gray encoding. On the source side, the live counter is copied into a snapshot register. That snapshot is then held frozen while a single toggle bit travels to the destination through a flip-flop synchronizer. The destination notices the toggle edge and captures the frozen snapshot. It then returns the toggle, through a second synchronizer, as an acknowledge.

Only the one-bit request and the one-bit acknowledge are resynchronized. The multi-bit value is never sampled while it can change, so transient decoding errors from bits that switch at different moments cannot reach the destination. The cost is latency. A new snapshot cannot be taken until the acknowledge has come back, so the destination view can lag the source by several periods of both clocks. With very unequal clocks this lag can be dozens of fast-clock cycles. Downstream full/empty logic consumes `dst_ptr` and `dst_upd` in the destination domain.

Top module: `ptr_handshake_xfer`

## Requirements
- R1: While its reset input is low at a rising edge, each domain clears its state. After such an edge, `dst_ptr` reads 0 and `dst_upd` reads 0, whatever `src_count` holds.
- R2: `dst_ptr` changes only on the destination edge that also raises `dst_upd`. `dst_upd` is never high on two consecutive destination cycles.
- R3: Every value taken by `dst_ptr` is a value that `src_count` presented at a source rising edge since reset. This holds even when the source skips values between destination samples.
- R4: While the source count only increases, each new `dst_ptr` value is strictly greater than the one before it.
- R5: Once `src_count` stops changing, `dst_ptr` settles to that final value within a bounded number of destination cycles.
- R6: When `dst_upd` is high, the value presented on `dst_ptr` differs from the value it held in the previous destination cycle.
- R7: A snapshot in flight stays unchanged from the moment its request toggles until the acknowledge toggle returns to the source domain.
- R8: A new request is issued only when the live count differs from the last snapshot. A constant source produces no `dst_upd` pulses.
- R9: Starting from an idle, settled state, a one-step source change shows up as `dst_upd` within 3 source periods plus (SYNC_STAGES+3) destination periods.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| src_clk | input | 1 | Source domain clock |
| src_rst_n | input | 1 | Source domain reset, active low, sampled on src_clk |
| src_count | input | PTR_W | Live binary pointer in the source domain |
| dst_clk | input | 1 | Destination domain clock |
| dst_rst_n | input | 1 | Destination domain reset, active low, sampled on dst_clk |
| dst_ptr | output | PTR_W | Registered copy of the pointer in the destination domain |
| dst_upd | output | 1 | One-cycle pulse marking a new `dst_ptr` value |

## Verification
The bench sweeps three clock ratios (slow destination at 10:1, fast destination near 1:3, and near-equal clocks). Within each ratio it drives source patterns with irregular step sizes and dwell times, so many source values are skipped before the destination can look. A design that sampled a changing snapshot would show a pointer value the source never held. A design that reordered or double-fired its handshake would make the pointer step backwards or pulse with no change. A wrong reset or a lost final toggle would leave the pointer stuck short of the final count. A missing compare against the snapshot would produce spurious pulses while the source is constant. Single-step latency is timed to catch a synchronizer chain that is longer than specified or an acknowledge that is never returned.

// File: rtl/ptrx_pkg.sv
// Package: shared constants and helpers for the pointer crossing.
// Assumes: every synchronizer chain has at least two stages.
package ptrx_pkg;

    // Smallest synchronizer chain the design accepts.
    localparam int unsigned PTRX_MIN_SYNC = 2;

    // Returns 1 when a toggle bit differs from the last value seen.
    function automatic logic tgl_pending(input logic tgl_now, input logic tgl_seen);
        return tgl_now ^ tgl_seen;
    endfunction

endpackage

// File: rtl/ptrx_sync.sv
// Module: single-bit resynchronizer built from a chain of flip-flops.
// Assumes: d_async is a level that is held for at least several clk periods;
//          reset is synchronous and active low.
module ptrx_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_async,
    output logic q_sync
);
    import ptrx_pkg::*;

    localparam int unsigned N = (STAGES < PTRX_MIN_SYNC) ? PTRX_MIN_SYNC : STAGES;

    logic [N-1:0] chain_q;

    // Shift the asynchronous level through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain_q <= '0;
        end else begin
            chain_q <= {chain_q[N-2:0], d_async};
        end
    end

    assign q_sync = chain_q[N-1];

endmodule

// File: rtl/ptrx_src_side.sv
// Module: source half of the crossing. Freezes a snapshot of the live
//         counter and flips a request toggle for each new snapshot.
// Assumes: ack_sync is the destination's acknowledge toggle, already
//          resynchronized to clk; reset is synchronous and active low.
module ptrx_src_side #(
    parameter int unsigned PTR_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [PTR_W-1:0] live_cnt,
    input  logic             ack_sync,
    output logic [PTR_W-1:0] snap_q,
    output logic             req_tgl
);
    import ptrx_pkg::*;

    logic idle;
    logic changed;
    logic load;

    // The handshake is idle once the acknowledge has caught up with the request.
    always_comb begin
        idle    = !tgl_pending(req_tgl, ack_sync);
        changed = (live_cnt != snap_q);
        load    = idle && changed;
    end

    // Take a new snapshot and raise a request only when idle and the count moved.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            snap_q  <= '0;
            req_tgl <= 1'b0;
        end else if (load) begin
            snap_q  <= live_cnt;
            req_tgl <= ~req_tgl;
        end
    end

endmodule

// File: rtl/ptrx_dst_side.sv
// Module: destination half of the crossing. Detects a new request toggle,
//         captures the frozen snapshot, pulses an update and returns the
//         toggle as acknowledge.
// Assumes: snap_in is stable whenever req_sync differs from the acknowledge;
//          reset is synchronous and active low.
module ptrx_dst_side #(
    parameter int unsigned PTR_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_sync,
    input  logic [PTR_W-1:0] snap_in,
    output logic [PTR_W-1:0] ptr_q,
    output logic             upd_q,
    output logic             ack_tgl
);
    import ptrx_pkg::*;

    logic take;

    // A new request is pending when the synchronized toggle differs from the acknowledge.
    always_comb begin
        take = tgl_pending(req_sync, ack_tgl);
    end

    // Capture the snapshot, pulse the strobe and echo the toggle back.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr_q   <= '0;
            upd_q   <= 1'b0;
            ack_tgl <= 1'b0;
        end else begin
            upd_q <= take;
            if (take) begin
                ptr_q   <= snap_in;
                ack_tgl <= req_sync;
            end
        end
    end

endmodule

// File: rtl/ptr_handshake_xfer.sv
// Module: top of the handshaked binary pointer crossing.
// Assumes: src_clk and dst_clk are unrelated; each reset is synchronous to
//          its own clock and both are asserted together at start-up.
module ptr_handshake_xfer #(
    parameter int unsigned PTR_W       = 5,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic             src_clk,
    input  logic             src_rst_n,
    input  logic [PTR_W-1:0] src_count,
    input  logic             dst_clk,
    input  logic             dst_rst_n,
    output logic [PTR_W-1:0] dst_ptr,
    output logic             dst_upd
);
    logic [PTR_W-1:0] snap_q;
    logic             req_tgl;
    logic             req_sync;
    logic             ack_tgl;
    logic             ack_sync;

    ptrx_src_side #(.PTR_W(PTR_W)) u_src (
        .clk      (src_clk),
        .rst_n    (src_rst_n),
        .live_cnt (src_count),
        .ack_sync (ack_sync),
        .snap_q   (snap_q),
        .req_tgl  (req_tgl)
    );

    ptrx_sync #(.STAGES(SYNC_STAGES)) u_req_sync (
        .clk     (dst_clk),
        .rst_n   (dst_rst_n),
        .d_async (req_tgl),
        .q_sync  (req_sync)
    );

    ptrx_dst_side #(.PTR_W(PTR_W)) u_dst (
        .clk      (dst_clk),
        .rst_n    (dst_rst_n),
        .req_sync (req_sync),
        .snap_in  (snap_q),
        .ptr_q    (dst_ptr),
        .upd_q    (dst_upd),
        .ack_tgl  (ack_tgl)
    );

    ptrx_sync #(.STAGES(SYNC_STAGES)) u_ack_sync (
        .clk     (src_clk),
        .rst_n   (src_rst_n),
        .d_async (ack_tgl),
        .q_sync  (ack_sync)
    );

endmodule

// File: rtl/ptr_handshake_xfer_chk.sv
// Module: property checker for the pointer crossing, bound to the top.
// Assumes: observes top-level ports plus the snapshot and toggle nets.
module ptr_handshake_xfer_chk #(
    parameter int unsigned PTR_W = 5
) (
    input logic             src_clk,
    input logic             src_rst_n,
    input logic             dst_clk,
    input logic             dst_rst_n,
    input logic [PTR_W-1:0] dst_ptr,
    input logic             dst_upd,
    input logic [PTR_W-1:0] snap_q,
    input logic             req_tgl,
    input logic             ack_sync
);

    AST_RESET_CLEARS: assert property (@(posedge dst_clk)
        !dst_rst_n |=> (dst_ptr == '0 && !dst_upd)); // R1

    AST_PTR_MOVES_ONLY_WITH_UPD: assert property (@(posedge dst_clk) disable iff (!dst_rst_n)
        !dst_upd |-> $stable(dst_ptr)); // R2

    AST_UPD_SINGLE_CYCLE: assert property (@(posedge dst_clk) disable iff (!dst_rst_n)
        dst_upd |=> !dst_upd); // R2

    AST_UPD_BRINGS_NEW_VALUE: assert property (@(posedge dst_clk) disable iff (!dst_rst_n)
        dst_upd |-> (dst_ptr != $past(dst_ptr))); // R6

    AST_SNAP_FROZEN: assert property (@(posedge src_clk) disable iff (!src_rst_n)
        (req_tgl != ack_sync) |=> $stable(snap_q)); // R7

    AST_REQ_ONLY_ON_NEW_SNAP: assert property (@(posedge src_clk) disable iff (!src_rst_n)
        (req_tgl != $past(req_tgl)) |-> (snap_q != $past(snap_q))); // R8

endmodule

bind ptr_handshake_xfer ptr_handshake_xfer_chk #(.PTR_W(PTR_W)) u_chk (
    .src_clk   (src_clk),
    .src_rst_n (src_rst_n),
    .dst_clk   (dst_clk),
    .dst_rst_n (dst_rst_n),
    .dst_ptr   (dst_ptr),
    .dst_upd   (dst_upd),
    .snap_q    (snap_q),
    .req_tgl   (req_tgl),
    .ack_sync  (ack_sync)
);

// File: tb/tb_ptr_handshake_xfer.sv
`timescale 1ns/1ps
module tb_ptr_handshake_xfer;
    localparam int unsigned PTR_W = 5;
    localparam int unsigned SYNC_STAGES = 2;
    localparam real SRC_HALF = 2.5; // 200 MHz source clock

    logic             src_clk = 1'b0;
    logic             dst_clk = 1'b0;
    logic             src_rst_n = 1'b0;
    logic             dst_rst_n = 1'b0;
    logic [PTR_W-1:0] src_count = '0;
    logic [PTR_W-1:0] dst_ptr;
    logic             dst_upd;

    real dst_half = 25.0;

    int n_chk = 0;
    int n_bad = 0;
    logic [31:0] held_mask = 32'h1;
    int last_ptr = 0;
    int upd_cnt = 0;

    ptr_handshake_xfer #(.PTR_W(PTR_W), .SYNC_STAGES(SYNC_STAGES)) dut (
        .src_clk   (src_clk),
        .src_rst_n (src_rst_n),
        .src_count (src_count),
        .dst_clk   (dst_clk),
        .dst_rst_n (dst_rst_n),
        .dst_ptr   (dst_ptr),
        .dst_upd   (dst_upd)
    );

    always #(SRC_HALF) src_clk = ~src_clk;
    always #(dst_half) dst_clk = ~dst_clk;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    // Monitor: every update must carry a held value (R3) larger than the last (R4).
    always @(negedge dst_clk) begin
        if (!dst_rst_n) begin
            last_ptr = 0;
        end else if (dst_upd) begin
            upd_cnt++;
            check(held_mask[dst_ptr] == 1'b1, "R3", int'(dst_ptr), -1);
            check(int'(dst_ptr) > last_ptr, "R4", int'(dst_ptr), last_ptr + 1);
            last_ptr = int'(dst_ptr);
        end
    end

    task automatic apply_reset();
        src_rst_n = 1'b0;
        dst_rst_n = 1'b0;
        src_count = 5'd7;
        repeat (4) @(posedge dst_clk);
        repeat (4) @(posedge src_clk);
        @(negedge dst_clk);
        check(dst_ptr == '0, "R1 ptr", int'(dst_ptr), 0);
        check(dst_upd == 1'b0, "R1 upd", int'(dst_upd), 0);
        @(negedge src_clk);
        src_count = '0;
        held_mask = 32'h1;
        repeat (3) @(posedge src_clk);
        @(negedge src_clk);
        src_rst_n = 1'b1;
        @(negedge dst_clk);
        dst_rst_n = 1'b1;
    endtask

    task automatic run_case(input real half, input int final_v, input int step_max,
                            input int gap_max, input int seed);
        int cur;
        bit hit;
        int idle_pulses;
        real t0;
        real bound;
        dst_half = half;
        apply_reset();
        cur = 0;
        for (int i = 0; cur < final_v; i++) begin
            int step;
            int gap;
            step = 1 + ((i * 7 + seed) % step_max);
            gap  = 1 + ((i * 3 + seed) % gap_max);
            cur  = (cur + step > final_v) ? final_v : cur + step;
            @(negedge src_clk);
            held_mask[cur] = 1'b1;
            src_count = cur[PTR_W-1:0];
            repeat (gap) @(posedge src_clk);
        end
        // R5: settle to the final count
        hit = 1'b0;
        for (int k = 0; k < 100 && !hit; k++) begin
            @(negedge dst_clk);
            if (dst_ptr == final_v[PTR_W-1:0]) hit = 1'b1;
        end
        check(hit, "R5", int'(dst_ptr), final_v);
        // R8: constant source gives no pulses
        repeat (10) @(negedge dst_clk);
        idle_pulses = upd_cnt;
        repeat (40) @(negedge dst_clk);
        check(upd_cnt == idle_pulses, "R8", upd_cnt - idle_pulses, 0);
        check(dst_ptr == final_v[PTR_W-1:0], "R8 ptr", int'(dst_ptr), final_v);
        // R9: single-step latency from a settled state
        @(negedge src_clk);
        held_mask[final_v + 1] = 1'b1;
        src_count = PTR_W'(final_v + 1);
        t0 = $realtime;
        bound = 3.0 * 2.0 * SRC_HALF + real'(SYNC_STAGES + 3) * 2.0 * half;
        hit = 1'b0;
        while (!hit && ($realtime - t0) <= bound) begin
            #0.1;
            if (dst_upd) hit = 1'b1;
        end
        check(hit, "R9", int'($realtime - t0), int'(bound));
        repeat (4) @(negedge dst_clk);
        check(dst_ptr == PTR_W'(final_v + 1), "R9 ptr", int'(dst_ptr), final_v + 1);
    endtask

    initial begin
        run_case(25.0, 28, 3, 4, 1); // slow destination, 10:1
        run_case(0.9, 29, 2, 3, 2);  // fast destination, about 1:3
        run_case(2.3, 30, 4, 2, 5);  // near-equal clocks
        run_case(25.0, 20, 1, 1, 0); // slow destination, unit steps every cycle
        finish_run();
    end

    initial begin
        repeat (150000) @(posedge src_clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        finish_run();
    end

endmodule